// File: doc/BRIEF.md
# Cascadable LCD Column Driver

This block is the digital front end of an 80-column LCD segment driver. Display data arrives four bits at a time, each nibble taken on the falling edge of a shift strobe and written into an 80-bit staging register. A falling edge on a load strobe copies the staging register into an output latch. Each column then emits a 2-bit code that selects one of four drive voltages. The code depends on the latched bit, the frame alternation input and a display-enable input. The analog level generation sits outside the block.

Several drivers can share one nibble bus in a chain. Each chip holds a disable flip-flop that stops intake once 80 bits are in, and it passes enable on to the next chip through a cascade pin. A direction input picks which cascade side is the enable input and which side drives the next chip. The same input sets whether nibbles fill the columns upward from column 1 or downward from column 80.

The shift and load strobes are sampled by a faster system clock, so the design is fully synchronous. The intake controller is a state machine with three states:
- `ST_IDLE`: no nibble accepted since the last load.
- `ST_FILL`: some nibbles accepted.
- `ST_FULL`: all 20 nibbles accepted, so the disable flip-flop is set.

Its transitions are:
- `ST_IDLE -> ST_FILL` on the first accepted nibble.
- `ST_FILL -> ST_FILL` on each further accepted nibble, with the counter advanced.
- `ST_FILL -> ST_FULL` on the 20th accepted nibble.
- Any state `-> ST_IDLE` on a load falling edge.

Top module: `lcd_col_drv`

## Requirements
- R1: With `dir`=0, the n-th nibble accepted since the last load (n counted from 0) writes `din[k]` into column 4n+k+1. Column c is reported on `col_code[2c-1:2c-2]`.
- R2: With `dir`=1, the n-th accepted nibble writes `din[k]` into column 80-4n-k.
- R3: A falling edge of `shift_clk` is accepted only when the selected enable pin is low and the chip is not full. The selected pin is `casc_r_in` when `dir`=0 and `casc_l_in` when `dir`=1. A nibble that is not accepted changes no stored bit.
- R4: With `dir`=0, `casc_l_oe`=1 and `casc_r_oe`=0; with `dir`=1 the two are swapped. Both cascade outputs carry the chain level: high (1) until the chip is full, then low (0).
- R5: After 20 accepted nibbles the chip is full, and every further nibble is ignored until the next load edge.
- R6: On a falling edge of `load_clk`, the staging register is copied into the latch. Column codes never change because of shift activity.
- R7: A load falling edge clears the nibble counter and the full flag. The chain level returns high, and the next accepted nibble goes to the first position again.
- R8: With `disp_en`=1, each column's code follows its latched bit d and `alt_m`: d=0,m=0 gives 01 (V3); d=1,m=0 gives 00 (V1); d=0,m=1 gives 10 (V4); d=1,m=1 gives 11 (VEE).
- R9: With `disp_en`=0, every column code is 00 (V1), whatever the data and `alt_m` are.
- R10: After reset the counter is 0, the chip is not full, the staging register and latch hold zeros, and both cascade outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_clk | input | 1 | Nibble strobe, falling edge active |
| load_clk | input | 1 | Latch strobe, falling edge active |
| din | input | 4 | Display data nibble |
| dir | input | 1 | Fill order and cascade role select |
| alt_m | input | 1 | Frame alternation signal |
| disp_en | input | 1 | 1 = show data, 0 = force V1 |
| casc_r_in | input | 1 | Right cascade pin input value |
| casc_r_out | output | 1 | Right cascade pin output value |
| casc_r_oe | output | 1 | Right cascade pin drive enable |
| casc_l_in | input | 1 | Left cascade pin input value |
| casc_l_out | output | 1 | Left cascade pin output value |
| casc_l_oe | output | 1 | Left cascade pin drive enable |
| col_code | output | 160 | 2-bit level code per column, column 1 in the lowest bits |

## Verification
Some behaviours are checked by assertions on every cycle:
- the counter stays in range;
- a full chip stays full until a load;
- a load clears the controller;
- staging and latch contents stay still without a write or load edge;
- blanking forces code 00.

Other behaviours only the bench scenarios can show. These are the column placement for each fill direction, the swap of enable pins, the 20-nibble cutoff, and how a partial fill interacts with a load. The bench shows them by comparing whole column vectors against a model after each load and after each change of polarity.

// File: rtl/lcd_col_pkg.sv
package lcd_col_pkg;

    typedef enum logic [1:0] {
        LVL_V1  = 2'b00,
        LVL_V3  = 2'b01,
        LVL_V4  = 2'b10,
        LVL_VEE = 2'b11
    } lvl_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_FILL = 2'b01,
        ST_FULL = 2'b10
    } intake_e;

    function automatic lvl_e pick_level(input logic d, input logic m, input logic en);
        lvl_e r;
        if (!en) begin
            r = LVL_V1;
        end else begin
            unique case ({m, d})
                2'b00:   r = LVL_V3;
                2'b01:   r = LVL_V1;
                2'b10:   r = LVL_V4;
                default: r = LVL_VEE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/lcd_fall_det.sv
module lcd_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign fall = prev_q & ~lvl;
endmodule

// File: rtl/lcd_intake_fsm.sv
module lcd_intake_fsm
    import lcd_col_pkg::*;
#(
    parameter int GROUPS = 20,
    localparam int CW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_fall,
    input  logic          load_fall,
    input  logic          en_n,
    output logic          wr_en,
    output logic [CW-1:0] wr_idx,
    output logic          chain_o
);
    intake_e       state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          accept;

    assign accept = shift_fall & ~en_n & ~load_fall & (state_q != ST_FULL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_fall) begin
                    cnt_d = '0;
                end else if (accept) begin
                    if (GROUPS == 1) begin
                        state_d = ST_FULL;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_FILL;
                        cnt_d   = CW'(1);
                    end
                end
            end
            ST_FILL: begin
                if (load_fall) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (accept) begin
                    if (cnt_q == CW'(GROUPS - 1)) begin
                        state_d = ST_FULL;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            ST_FULL: begin
                if (load_fall) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        wr_en   = accept;
        wr_idx  = cnt_q;
        chain_o = (state_q != ST_FULL);
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < GROUPS);
    p_full_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && !load_fall) |=> (state_q == ST_FULL));
    p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_fall |=> (state_q == ST_IDLE && cnt_q == '0));
endmodule

// File: rtl/lcd_col_store.sv
module lcd_col_store #(
    parameter int NCOLS = 80,
    parameter int NIB   = 4,
    localparam int GROUPS = NCOLS / NIB,
    localparam int CW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_idx,
    input  logic             dir,
    input  logic [NIB-1:0]   din,
    input  logic             load_fall,
    output logic [NCOLS-1:0] latched
);
    logic [NCOLS-1:0] sr_q, sr_d;

    always_comb begin
        sr_d = sr_q;
        if (wr_en) begin
            for (int c = 0; c < NCOLS; c++) begin
                if (!dir && int'(wr_idx) == c / NIB)
                    sr_d[c] = din[c % NIB];
                else if (dir && int'(wr_idx) == (NCOLS - 1 - c) / NIB)
                    sr_d[c] = din[(NCOLS - 1 - c) % NIB];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         latched <= '0;
        else if (load_fall) latched <= sr_q;
    end

    p_sr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sr_q));
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_fall |=> $stable(latched));
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
    import lcd_col_pkg::*;
#(
    parameter int NCOLS = 80
) (
    input  logic [NCOLS-1:0]   latched,
    input  logic               alt_m,
    input  logic               disp_en,
    output logic [2*NCOLS-1:0] col_code
);
    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        assign col_code[2*c +: 2] = pick_level(latched[c], alt_m, disp_en);
    end
endmodule

// File: rtl/lcd_col_drv.sv
module lcd_col_drv #(
    parameter int NCOLS = 80,
    parameter int NIB   = 4,
    localparam int GROUPS = NCOLS / NIB,
    localparam int CW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_clk,
    input  logic               load_clk,
    input  logic [NIB-1:0]     din,
    input  logic               dir,
    input  logic               alt_m,
    input  logic               disp_en,
    input  logic               casc_r_in,
    output logic               casc_r_out,
    output logic               casc_r_oe,
    input  logic               casc_l_in,
    output logic               casc_l_out,
    output logic               casc_l_oe,
    output logic [2*NCOLS-1:0] col_code
);
    logic          shift_fall, load_fall, en_n, wr_en, chain_o;
    logic [CW-1:0] wr_idx;
    logic [NCOLS-1:0] latched;

    lcd_fall_det u_shift_edge (.clk(clk), .rst_n(rst_n), .lvl(shift_clk), .fall(shift_fall));
    lcd_fall_det u_load_edge  (.clk(clk), .rst_n(rst_n), .lvl(load_clk),  .fall(load_fall));

    assign en_n = dir ? casc_l_in : casc_r_in;

    lcd_intake_fsm #(.GROUPS(GROUPS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .shift_fall(shift_fall), .load_fall(load_fall),
        .en_n(en_n), .wr_en(wr_en), .wr_idx(wr_idx), .chain_o(chain_o)
    );

    lcd_col_store #(.NCOLS(NCOLS), .NIB(NIB)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .dir(dir),
        .din(din), .load_fall(load_fall), .latched(latched)
    );

    lcd_level_enc #(.NCOLS(NCOLS)) u_enc (
        .latched(latched), .alt_m(alt_m), .disp_en(disp_en), .col_code(col_code)
    );

    assign casc_l_out = chain_o;
    assign casc_r_out = chain_o;
    assign casc_l_oe  = ~dir;
    assign casc_r_oe  = dir;

    p_blank_v1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> (col_code == '0));
    p_chain_rises_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_fall |=> chain_o);
endmodule

// File: tb/lcd_col_drv_tb_top.sv
module lcd_col_drv_tb_top;
    localparam int PERIOD = 10;
    localparam int NC = 80;
    localparam int NG = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic shift_clk = 1'b0, load_clk = 1'b0;
    logic [3:0] din = '0;
    logic dir = 1'b0, alt_m = 1'b0, disp_en = 1'b1;
    logic casc_r_in = 1'b1, casc_l_in = 1'b1;
    logic casc_r_out, casc_r_oe, casc_l_out, casc_l_oe;
    logic [2*NC-1:0] col_code;

    always #(PERIOD/2) clk = ~clk;

    lcd_col_drv dut_i (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .load_clk(load_clk),
        .din(din), .dir(dir), .alt_m(alt_m), .disp_en(disp_en),
        .casc_r_in(casc_r_in), .casc_r_out(casc_r_out), .casc_r_oe(casc_r_oe),
        .casc_l_in(casc_l_in), .casc_l_out(casc_l_out), .casc_l_oe(casc_l_oe),
        .col_code(col_code)
    );

    int n_cmp = 0, n_bad = 0;

    // reference model state
    logic [NC-1:0] m_sr = '0, m_lat = '0;
    int m_cnt = 0;
    bit m_full = 0;

    typedef struct {
        string           tag;
        logic [2*NC-1:0] v;
    } item_t;
    item_t sb_q[$];
    event  sb_ev;

    function automatic logic [1:0] ref_code(logic d, logic m, logic en);
        if (!en) return 2'b00;
        if (!m && !d) return 2'b01;
        if (!m &&  d) return 2'b00;
        if ( m && !d) return 2'b10;
        return 2'b11;
    endfunction

    function automatic logic [2*NC-1:0] ref_vec();
        logic [2*NC-1:0] r;
        for (int c = 0; c < NC; c++) r[2*c +: 2] = ref_code(m_lat[c], alt_m, disp_en);
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // monitor: pops expected vectors and compares with the column outputs
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (col_code !== it.v) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, col_code, it.v);
                end
            end
        end
    end

    task automatic expect_cols(string tag);
        item_t it;
        it.tag = tag;
        it.v   = ref_vec();
        sb_q.push_back(it);
        ->sb_ev;
        #1;
    endtask

    task automatic send_nib(logic [3:0] d);
        logic en_pin;
        @(negedge clk);
        din = d;
        shift_clk = 1'b1;
        @(negedge clk);
        shift_clk = 1'b0;
        @(negedge clk);
        en_pin = dir ? casc_l_in : casc_r_in;
        if (!en_pin && !m_full) begin
            for (int j = 0; j < 4; j++) begin
                if (!dir) m_sr[4*m_cnt + j] = d[j];
                else      m_sr[NC-1 - 4*m_cnt - j] = d[j];
            end
            m_cnt++;
            if (m_cnt == NG) begin
                m_full = 1;
                m_cnt = 0;
            end
        end
    endtask

    task automatic do_load();
        @(negedge clk);
        load_clk = 1'b1;
        @(negedge clk);
        load_clk = 1'b0;
        @(negedge clk);
        m_lat = m_sr;
        m_cnt = 0;
        m_full = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        expect_cols("R10 reset columns");
        check("R10 left chain out", 32'(casc_l_out), 1);
        check("R10 right chain out", 32'(casc_r_out), 1);
        check("R4 left oe dir0", 32'(casc_l_oe), 1);
        check("R4 right oe dir0", 32'(casc_r_oe), 0);

        // R3 wrong pin low: nibbles ignored
        casc_r_in = 1'b1;
        casc_l_in = 1'b0;
        for (int i = 0; i < 3; i++) send_nib(4'hF);
        do_load();
        expect_cols("R3 ignored with enable pin high");

        // R1 full fill dir=0, R5 cutoff, R6 no change before load
        casc_r_in = 1'b0;
        casc_l_in = 1'b1;
        for (int i = 0; i < NG - 1; i++) send_nib(4'((i * 7 + 3) & 15));
        check("R4 chain high before full", 32'(casc_l_out), 1);
        send_nib(4'h9);
        check("R5 chain low when full", 32'(casc_l_out), 0);
        check("R4 right out follows chain", 32'(casc_r_out), 0);
        expect_cols("R6 columns unchanged by shifting");
        send_nib(4'h6);
        do_load();
        expect_cols("R1 ascending fill after load");
        check("R7 chain high after load", 32'(casc_l_out), 1);

        // R8 polarity and R9 blanking
        alt_m = 1'b1;
        @(negedge clk);
        expect_cols("R8 alternation high");
        disp_en = 1'b0;
        @(negedge clk);
        expect_cols("R9 blanked columns");
        disp_en = 1'b1;
        alt_m = 1'b0;
        @(negedge clk);
        expect_cols("R8 alternation low");

        // R7 partial fill then restart from first position
        for (int i = 0; i < 3; i++) send_nib(4'(i + 5));
        do_load();
        expect_cols("R7 partial fill");
        send_nib(4'hA);
        do_load();
        expect_cols("R7 restart at first group");

        // R2 / R4 reverse direction
        dir = 1'b1;
        @(negedge clk);
        check("R4 left oe dir1", 32'(casc_l_oe), 0);
        check("R4 right oe dir1", 32'(casc_r_oe), 1);
        casc_r_in = 1'b0;
        casc_l_in = 1'b1;
        send_nib(4'h3);
        send_nib(4'hC);
        do_load();
        expect_cols("R3 right pin ignored in dir1");
        casc_l_in = 1'b0;
        casc_r_in = 1'b1;
        for (int i = 0; i < NG; i++) send_nib(4'((i * 11 + 1) & 15));
        check("R4 right chain low when full dir1", 32'(casc_r_out), 0);
        do_load();
        alt_m = 1'b1;
        @(negedge clk);
        expect_cols("R2 descending fill");

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule